// File: doc/BRIEF.md
# I2C Slave Front End with Stuck-Bus Timeout

This block is the serial front end of a memory-style device on a two-wire bus. The system clock oversamples the bus. SCL and SDA each pass through a two-flop synchronizer. Edge logic then finds the clock edges and the START and STOP conditions, including a repeated START. A byte engine collects the address byte MSB first and compares its seven address bits with a fixed upper part `101` followed by a four-bit strap input. It then either receives write bytes or sends read bytes, MSB first. The block only pulls SDA low and has no SCL output, so it never stretches the clock.

The back end sees two byte streams. Received bytes leave through a valid/ready stream. A byte is offered once its eighth bit has been sampled, and it is acknowledged on the bus only if the back end accepts it before the SCL falling edge that ends that eighth bit. `rx_valid_o` holds its data stable until acceptance or until that edge. If the edge comes first, the offer is withdrawn and the byte is refused. Read bytes enter through a second valid/ready stream. `tx_ready_o` is high while a byte is wanted: during the address ACK of a read, and during a master ACK after it has been sampled. Because the bus cannot be held, a byte not taken by the next SCL falling edge is replaced by 0xFF, which means SDA stays released.

A `busy_i` input makes the block refuse the address and hold back write offers, for example while a long internal operation runs. When `tmo_en_i` is 1, a frame in which SCL stays at one level, or SDA stays low, for `TMO_CYCLES` clocks is closed as if a STOP had arrived.

Top module: `i2c_tmo_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal `101` followed by `addr_lo_i[3:0]` (MSB first) by pulling SDA low during the ninth clock. On a mismatch it does not pull SDA, and it ignores every later bit until the next START or STOP.
- R2: A START (SDA falling while SCL is high) restarts the address phase from any state, so a repeated START with no STOP before it begins a new transfer.
- R3: In a write (address bit 0 = 0), each data byte is sampled MSB first on SCL rising edges and offered on `rx_data_o`. `rx_first_o` is 1 for the first byte offered after the address and 0 for the bytes that follow.
- R4: While `rx_valid_o` is high and `rx_ready_i` is low, `rx_data_o` holds its value. A byte accepted before the SCL falling edge that ends bit 8 is acknowledged. Otherwise the slave withdraws the offer, leaves SDA released in the ACK slot, and ignores the bus until the next START or STOP.
- R5: In a read (address bit 0 = 1), the slave sends bytes MSB first, changing SDA only after SCL falling edges. A byte is taken when `tx_valid_i` and `tx_ready_o` are both high, after which `tx_ready_o` drops. If no byte was taken, 0xFF is sent.
- R6: After a read byte, a master ACK (SDA low at the ninth clock) makes the slave send another byte. A master NACK makes it release SDA and ignore the bus until the next START or STOP, with no further `tx_ready_o`.
- R7: With `busy_i` high at the falling edge after the address byte, the address is not acknowledged. A write byte completed while `busy_i` is high is never offered and is refused.
- R8: A STOP (SDA rising while SCL is high) ends the frame and releases SDA. If the slave was addressed in that frame, `stop_o` pulses for one clock.
- R9: With `tmo_en_i` = 1, once a frame is open, SCL unchanged for `TMO_CYCLES` clocks, or SDA low for `TMO_CYCLES` clocks, acts as a STOP. The slave releases SDA, pulses `stop_o` if it was addressed, and refuses the bytes that follow.
- R10: With `tmo_en_i` = 0, a stuck bus of any length has no effect on the transfer.
- R11: The slave begins pulling SDA low only while SCL is low, and the block has no SCL output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_lo_i | input | 4 | Lower four bits of the slave address |
| tmo_en_i | input | 1 | Enables the stuck-bus timeout |
| busy_i | input | 1 | Back end busy; forces NACK |
| rx_valid_o | output | 1 | Received byte offered |
| rx_ready_i | input | 1 | Back end accepts the received byte |
| rx_data_o | output | 8 | Received byte |
| rx_first_o | output | 1 | Offered byte is the first after the address |
| tx_valid_i | input | 1 | Read byte available |
| tx_ready_o | output | 1 | Slave wants a read byte |
| tx_data_i | input | 8 | Read byte |
| stop_o | output | 1 | One-clock pulse when an addressed frame ends |

## Verification
A wrong bit count or a wrong state in the byte engine shows at the port one bus bit later. The ACK slot of the byte then reads high where low was expected, or low where high was expected. Every following byte of the frame is then acknowledged or refused wrongly, and read data is shifted by one bit. A faulty timer shows as a `stop_o` pulse that is missing, or that appears during a stuck-bus hold. The next byte after the hold then exposes it through its ACK, within nine bus clocks. Faulty stream logic shows as a scoreboard mismatch in data or first flag at the handshake itself, or as a stream byte that is consumed and never sent.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_LO_W  = 4;
  localparam logic [2:0] ADDR_FIXED = 3'b101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } eng_st_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic scl_chg,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign scl_chg   = scl_s ^ scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_tmo.sv
module i2cs_tmo #(
  parameter int unsigned TMO_CYCLES = 3_750_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_chg,
  input  logic sda_s,
  input  logic start_evt,
  input  logic stop_evt,
  output logic tmo_hit
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TMO_CYCLES - 1);

  logic          active;
  logic [CW-1:0] c_scl, c_sda;

  assign tmo_hit = en & active & ((c_scl == LIMIT) | (c_sda == LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      c_scl  <= '0;
      c_sda  <= '0;
    end else begin
      if (stop_evt || tmo_hit) active <= 1'b0;
      else if (start_evt)      active <= 1'b1;

      if (!en || !active || scl_chg) c_scl <= '0;
      else if (c_scl != LIMIT)       c_scl <= c_scl + 1'b1;

      if (!en || !active || sda_s)   c_sda <= '0;
      else if (c_sda != LIMIT)       c_sda <= c_sda + 1'b1;
    end
  end
endmodule

// File: rtl/i2cs_eng.sv
module i2cs_eng
  import i2cs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_s,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_evt,
  input  logic                 stop_evt,
  input  logic                 tmo_hit,
  input  logic [ADDR_LO_W-1:0] addr_lo,
  input  logic                 busy,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [BYTE_W-1:0]    rx_data,
  output logic                 rx_first,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [BYTE_W-1:0]    tx_data,
  output logic                 sda_pull,
  output logic                 stop_pulse
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  eng_st_t           st;
  logic [BYTE_W-1:0] sh, txsh, tx_buf, ld_byte;
  logic [CNT_W-1:0]  cnt;
  logic              rw, sel, acc, mack, tx_have;

  wire rx_hs     = rx_valid & rx_ready;
  wire tx_hs     = tx_valid & tx_ready;
  wire byte_full = (cnt == CNT_W'(BYTE_W));
  wire last_bit  = (cnt == CNT_W'(BYTE_W - 1));
  wire addr_hit  = (sh[BYTE_W-1:1] == {ADDR_FIXED, addr_lo});
  wire acc_now   = acc | rx_hs;
  wire [BYTE_W-1:0] sh_next = {sh[BYTE_W-2:0], sda_s};

  assign tx_ready = ~tx_have & (((st == ST_ADDR_ACK) & rw) | ((st == ST_RD_ACK) & mack));

  always_comb begin
    if (tx_have)    ld_byte = tx_buf;
    else if (tx_hs) ld_byte = tx_data;
    else            ld_byte = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      sh         <= '0;
      txsh       <= '1;
      tx_buf     <= '0;
      cnt        <= '0;
      rw         <= 1'b0;
      sel        <= 1'b0;
      acc        <= 1'b0;
      mack       <= 1'b0;
      tx_have    <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_first   <= 1'b0;
      sda_pull   <= 1'b0;
      stop_pulse <= 1'b0;
    end else begin
      stop_pulse <= 1'b0;
      if (rx_hs) begin
        rx_valid <= 1'b0;
        acc      <= 1'b1;
        rx_first <= 1'b0;
      end
      if (tx_hs) begin
        tx_have <= 1'b1;
        tx_buf  <= tx_data;
      end

      if (stop_evt || tmo_hit) begin
        st         <= ST_IDLE;
        sda_pull   <= 1'b0;
        rx_valid   <= 1'b0;
        tx_have    <= 1'b0;
        stop_pulse <= sel;
        sel        <= 1'b0;
      end else if (start_evt) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
        rx_valid <= 1'b0;
        tx_have  <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= sh_next;
              cnt <= cnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              if (addr_hit && !busy) begin
                sda_pull <= 1'b1;
                st       <= ST_ADDR_ACK;
                rw       <= sh[0];
                sel      <= 1'b1;
                rx_first <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                sda_pull <= ~ld_byte[BYTE_W-1];
                txsh     <= {ld_byte[BYTE_W-2:0], 1'b1};
                cnt      <= CNT_W'(1);
                tx_have  <= 1'b0;
                st       <= ST_RD;
              end else begin
                sda_pull <= 1'b0;
                cnt      <= '0;
                acc      <= 1'b0;
                st       <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh  <= sh_next;
              cnt <= cnt + 1'b1;
              if (last_bit) begin
                acc <= 1'b0;
                if (!busy) begin
                  rx_valid <= 1'b1;
                  rx_data  <= sh_next;
                end
              end
            end else if (scl_fall && byte_full) begin
              rx_valid <= 1'b0;
              if (acc_now) begin
                sda_pull <= 1'b1;
                st       <= ST_WR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              cnt      <= '0;
              acc      <= 1'b0;
              st       <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (byte_full) begin
                sda_pull <= 1'b0;
                mack     <= 1'b0;
                st       <= ST_RD_ACK;
              end else begin
                sda_pull <= ~txsh[BYTE_W-1];
                txsh     <= {txsh[BYTE_W-2:0], 1'b1};
                cnt      <= cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                sda_pull <= ~ld_byte[BYTE_W-1];
                txsh     <= {ld_byte[BYTE_W-2:0], 1'b1};
                cnt      <= CNT_W'(1);
                tx_have  <= 1'b0;
                st       <= ST_RD;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: begin
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tmo_slave.sv
module i2c_tmo_slave
  import i2cs_pkg::*;
#(
  parameter int unsigned TMO_CYCLES  = 3_750_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_pull_o,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  input  logic                 tmo_en_i,
  input  logic                 busy_i,
  output logic                 rx_valid_o,
  input  logic                 rx_ready_i,
  output logic [BYTE_W-1:0]    rx_data_o,
  output logic                 rx_first_o,
  input  logic                 tx_valid_i,
  output logic                 tx_ready_o,
  input  logic [BYTE_W-1:0]    tx_data_i,
  output logic                 stop_o
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, scl_chg;
  logic start_evt, stop_evt, tmo_hit;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     ({scl_s, sda_s})
  );

  i2cs_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .scl_chg   (scl_chg),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2cs_tmo #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (tmo_en_i),
    .scl_chg   (scl_chg),
    .sda_s     (sda_s),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .tmo_hit   (tmo_hit)
  );

  i2cs_eng u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .tmo_hit    (tmo_hit),
    .addr_lo    (addr_lo_i),
    .busy       (busy_i),
    .rx_valid   (rx_valid_o),
    .rx_ready   (rx_ready_i),
    .rx_data    (rx_data_o),
    .rx_first   (rx_first_o),
    .tx_valid   (tx_valid_i),
    .tx_ready   (tx_ready_o),
    .tx_data    (tx_data_i),
    .sda_pull   (sda_pull_o),
    .stop_pulse (stop_o)
  );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_pull,
  input logic       stop_o,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       busy,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       stop_evt,
  input logic       tmo_hit,
  input logic       tmo_en
);
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (!rx_valid || $stable(rx_data))); // R4
  AST_TX_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R5
  AST_BUSY_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> !$past(busy)); // R7
  AST_STOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> !sda_pull); // R8
  AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> $past(stop_evt || tmo_hit)); // R8
  AST_TMO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |-> tmo_en); // R10
  AST_PULL_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s); // R11
endmodule

bind i2c_tmo_slave i2cs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .sda_pull (sda_pull_o),
  .stop_o   (stop_o),
  .rx_valid (rx_valid_o),
  .rx_ready (rx_ready_i),
  .rx_data  (rx_data_o),
  .busy     (busy_i),
  .tx_valid (tx_valid_i),
  .tx_ready (tx_ready_o),
  .stop_evt (stop_evt),
  .tmo_hit  (tmo_hit),
  .tmo_en   (tmo_en_i)
);

// File: tb/i2c_tmo_slave_bench.sv
`timescale 1ns/1ps
module i2c_tmo_slave_bench;
  localparam int TMO = 1000;
  localparam int Q   = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_pull_o;
  logic [3:0] addr_lo_i = 4'b0110;
  logic       tmo_en_i = 1'b0, busy_i = 1'b0;
  logic       rx_valid_o, rx_ready_i, rx_first_o;
  logic [7:0] rx_data_o;
  logic       tx_valid_i = 1'b0, tx_ready_o;
  logic [7:0] tx_data_i = 8'h00;
  logic       stop_o;
  wire        sda_line = sda_m & ~sda_pull_o;

  i2c_tmo_slave #(.TMO_CYCLES(TMO)) u_i2c_tmo_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .addr_lo_i(addr_lo_i), .tmo_en_i(tmo_en_i),
    .busy_i(busy_i), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
    .rx_data_o(rx_data_o), .rx_first_o(rx_first_o), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .tx_data_i(tx_data_i), .stop_o(stop_o)
  );

  int n_chk = 0, n_fail = 0;
  int n_stop = 0, rx_seen = 0, bad11 = 0, cyc = 0;
  bit done = 1'b0;
  logic [8:0] exp_rx[$];
  logic [7:0] tx_q[$];
  logic rx_rdy = 1'b1;
  assign rx_ready_i = rx_rdy;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor for received bytes
  always @(negedge clk) begin
    if (rst_n && rx_valid_o) rx_seen++;
    if (rst_n && rx_valid_o && rx_ready_i) begin
      if (exp_rx.size() == 0) chk(1'b0, "R3", "unexpected rx byte", rx_data_o, 0);
      else begin
        logic [8:0] e;
        e = exp_rx.pop_front();
        chk({rx_first_o, rx_data_o} == e, "R3", "rx first/data", {rx_first_o, rx_data_o}, e);
      end
    end
    if (stop_o) n_stop++;
  end

  // read byte feeder
  logic tx_hs_prev = 1'b0;
  always @(negedge clk) begin
    if (tx_hs_prev) void'(tx_q.pop_front());
    tx_valid_i = (tx_q.size() > 0);
    tx_data_i  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
    tx_hs_prev = tx_valid_i && tx_ready_o;
  end

  // R11: no new pull while the bus clock is high
  logic prev_pull = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (sda_pull_o && !prev_pull && scl_m && prev_scl) bad11++;
    prev_pull = sda_pull_o;
    prev_scl  = scl_m;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b1; wait_n(Q);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    sda_m = b;    wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    s = sda_line; wait_n(Q);
    scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(output logic [7:0] b, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      b[i] = s;
    end
    bit_xfer(~mack, s);
  endtask

  initial begin
    logic ack;
    logic [7:0] rd;
    int s0;
    wait_n(10);
    rst_n = 1'b1;
    wait_n(5);
    chk(sda_pull_o == 0, "R8", "reset sda_pull", sda_pull_o, 0);
    chk(rx_valid_o == 0, "R3", "reset rx_valid", rx_valid_o, 0);
    chk(tx_ready_o == 0, "R5", "reset tx_ready", tx_ready_o, 0);
    chk(stop_o == 0, "R8", "reset stop_o", stop_o, 0);

    // R1 R3 R8: plain write frame
    s0 = n_stop;
    exp_rx.push_back({1'b1, 8'hA5});
    exp_rx.push_back({1'b0, 8'h3C});
    bus_start();
    write_byte(8'hAC, ack); chk(ack == 1, "R1", "address ack", ack, 1);
    write_byte(8'hA5, ack); chk(ack == 1, "R3", "data ack 1", ack, 1);
    write_byte(8'h3C, ack); chk(ack == 1, "R3", "data ack 2", ack, 1);
    bus_stop(); wait_n(10);
    chk(n_stop - s0 == 1, "R8", "stop pulse", n_stop - s0, 1);
    chk(sda_pull_o == 0, "R8", "released after stop", sda_pull_o, 0);

    // R1 mismatch
    s0 = n_stop;
    bus_start();
    write_byte(8'hAE, ack); chk(ack == 0, "R1", "wrong address nack", ack, 0);
    write_byte(8'h55, ack); chk(ack == 0, "R1", "ignored after mismatch", ack, 0);
    bus_stop(); wait_n(10);
    chk(n_stop - s0 == 0, "R8", "no stop pulse unaddressed", n_stop - s0, 0);

    // R2 R5 R6: write, repeated start, read
    s0 = n_stop;
    exp_rx.push_back({1'b1, 8'h11});
    tx_q.push_back(8'hC3);
    tx_q.push_back(8'h5A);
    bus_start();
    write_byte(8'hAC, ack); chk(ack == 1, "R1", "address ack wr", ack, 1);
    write_byte(8'h11, ack); chk(ack == 1, "R3", "data ack", ack, 1);
    bus_start();
    write_byte(8'hAD, ack); chk(ack == 1, "R2", "repeated start address ack", ack, 1);
    read_byte(rd, 1'b1);    chk(rd == 8'hC3, "R5", "read byte 1", rd, 8'hC3);
    tx_q.push_back(8'h77);
    read_byte(rd, 1'b0);    chk(rd == 8'h5A, "R6", "read after master ack", rd, 8'h5A);
    read_byte(rd, 1'b1);    chk(rd == 8'hFF, "R6", "released after master nack", rd, 8'hFF);
    chk(tx_q.size() == 1, "R6", "no byte taken after nack", tx_q.size(), 1);
    bus_stop(); wait_n(10);
    chk(n_stop - s0 == 1, "R8", "stop pulse read frame", n_stop - s0, 1);

    // R5: byte present, then none
    bus_start();
    write_byte(8'hAD, ack); chk(ack == 1, "R5", "read address ack", ack, 1);
    read_byte(rd, 1'b1);    chk(rd == 8'h77, "R5", "queued read byte", rd, 8'h77);
    read_byte(rd, 1'b0);    chk(rd == 8'hFF, "R5", "empty stream sends FF", rd, 8'hFF);
    bus_stop(); wait_n(10);

    // R4: back-pressure refuses byte
    s0 = rx_seen;
    rx_rdy = 1'b0;
    bus_start();
    write_byte(8'hAC, ack); chk(ack == 1, "R4", "address ack", ack, 1);
    write_byte(8'h42, ack); chk(ack == 0, "R4", "unaccepted byte nack", ack, 0);
    chk(rx_seen > s0, "R4", "byte was offered", rx_seen - s0, 1);
    write_byte(8'h43, ack); chk(ack == 0, "R4", "ignored after refusal", ack, 0);
    bus_stop(); wait_n(10);
    rx_rdy = 1'b1;

    // R7: busy
    busy_i = 1'b1;
    bus_start();
    write_byte(8'hAC, ack); chk(ack == 0, "R7", "busy address nack", ack, 0);
    bus_stop(); wait_n(10);
    busy_i = 1'b0;
    bus_start();
    write_byte(8'hAC, ack); chk(ack == 1, "R7", "address ack not busy", ack, 1);
    s0 = rx_seen;
    busy_i = 1'b1;
    write_byte(8'h99, ack); chk(ack == 0, "R7", "busy data nack", ack, 0);
    chk(rx_seen == s0, "R7", "no offer while busy", rx_seen - s0, 0);
    busy_i = 1'b0;
    bus_stop(); wait_n(10);

    // R9: SCL stuck low
    tmo_en_i = 1'b1;
    s0 = n_stop;
    bus_start();
    write_byte(8'hAC, ack); chk(ack == 1, "R9", "address ack", ack, 1);
    wait_n(TMO + 200);
    chk(n_stop - s0 == 1, "R9", "timeout acts as stop (scl)", n_stop - s0, 1);
    chk(sda_pull_o == 0, "R9", "released on timeout", sda_pull_o, 0);
    write_byte(8'h21, ack); chk(ack == 0, "R9", "refused after timeout", ack, 0);
    bus_stop(); wait_n(10);
    chk(n_stop - s0 == 1, "R9", "no second pulse", n_stop - s0, 1);

    // R9: SDA stuck low with SCL running
    s0 = n_stop;
    rx_rdy = 1'b0;
    bus_start();
    write_byte(8'hAC, ack); chk(ack == 1, "R9", "address ack sda case", ack, 1);
    for (int i = 0; i < 30; i++) bit_xfer(1'b0, ack);
    chk(n_stop - s0 == 1, "R9", "timeout acts as stop (sda)", n_stop - s0, 1);
    bus_stop(); wait_n(10);
    rx_rdy = 1'b1;

    // R10: timeout disabled
    tmo_en_i = 1'b0;
    s0 = n_stop;
    exp_rx.push_back({1'b1, 8'h66});
    bus_start();
    write_byte(8'hAC, ack); chk(ack == 1, "R10", "address ack", ack, 1);
    wait_n(TMO + 200);
    chk(n_stop - s0 == 0, "R10", "no timeout when disabled", n_stop - s0, 0);
    write_byte(8'h66, ack); chk(ack == 1, "R10", "transfer continues", ack, 1);
    bus_stop(); wait_n(10);
    chk(n_stop - s0 == 1, "R10", "real stop only", n_stop - s0, 1);

    chk(bad11 == 0, "R11", "pull started while SCL high", bad11, 0);
    chk(exp_rx.size() == 0, "R3", "scoreboard drained", exp_rx.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule